// File: doc/BRIEF.md
# PHY Speed-Mode and DLL Configurator

This block brings the I/O PHY of a card host controller to the correct state whenever software asks for a new card clock frequency or bus timing. Each request gives a frequency code, a timing mode, an enhanced-strobe flag and a pad drive type, and starts with a one-cycle `cfg_start` pulse.

The block then issues an ordered series of register accesses on a byte-wide PHY register port. It sets the mode bits, rewrites the pad drive strength when the mode needs it, and sets the output and input tap delays and the DLL trim. It then resets the DLL, enables it with a frequency select, and polls the PHY until the DLL reports lock. The result is a one-cycle `cfg_done` pulse, with `cfg_error` raised in the same cycle if lock did not arrive in time.

The PHY register port is a valid/ready request channel. A request (`phy_req_*`) is held stable until the cycle in which `phy_req_valid` and `phy_req_ready` are both high, and that cycle transfers it. A write is complete at that transfer. A read waits for a later one-cycle `phy_rsp_valid` pulse carrying the byte. The response channel has no back-pressure, and the block accepts a response in any cycle it waits for one.

Top module: `phy_speed_cfg`

## Requirements
- R1: The first access of every sequence writes register 0x11 with the mode bits: enhanced strobe 0x01, HS400 0x02, legacy 0x04, DDR50 0x08, high-speed 0x00, HS200/SDR104 0x00. Timing codes are legacy 0, high-speed 1, HS200 2, DDR50 3, HS400 4.
- R2: Register 0x0D (output tap) is written before register 0x0C (input tap), each as (tap<<1)|1. The (output, input) taps are: high-speed (3,2), DDR50 (1,0), HS400 (1,10), enhanced strobe (1,0). HS200 writes 0x00 to the input tap. Legacy writes 0x00 to both.
- R3: Only for HS200 and HS400 without enhanced strobe, register 0x01 is read and then rewritten as read-value OR (drive type << 2). This happens between the mode write and the tap writes.
- R4: Every mode except legacy writes 0x08 to register 0x12 after the tap writes.
- R5: Register 0x00 is then always written with 0x00. Outside legacy mode it is next written with (fsel<<5)|0x08 and read repeatedly until bit 4 reads 1. The frequency codes are 0=200 MHz, 1=100 MHz, 2=50 MHz and 3=other, which give fsel 0, 2, 1 and 0.
- R6: If no read of register 0x00 shows bit 4 within POLL_LIMIT cycles of the DLL enable write, `cfg_done` and `cfg_error` pulse together. `cfg_error` is never high without `cfg_done`.
- R7: A start whose frequency code equals the code of the previous accepted start issues no PHY access and still pulses `cfg_done`.
- R8: With the enhanced-strobe flag set, the enhanced-strobe settings are used whatever the timing code.
- R9: Timing codes 5 to 7 without enhanced strobe issue no PHY access and pulse `cfg_done`.
- R10: `cfg_done` lasts one cycle per accepted start. A start that arrives while a sequence runs is ignored. No request follows `cfg_done` until the next start.
- R11: While `phy_req_valid` is high and `phy_req_ready` is low, the request fields and `phy_req_valid` stay unchanged in the next cycle.
- R12: After reset `cfg_done`, `cfg_error` and `phy_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | One-cycle request to reprogram |
| cfg_freq | input | 2 | Frequency code (0=200,1=100,2=50,3=other MHz) |
| cfg_timing | input | 3 | Bus timing code |
| cfg_enh_strobe | input | 1 | Enhanced-strobe override |
| cfg_drv_type | input | DRV_W | Pad drive type |
| phy_req_valid | output | 1 | PHY request valid |
| phy_req_ready | input | 1 | PHY accepts request |
| phy_req_write | output | 1 | 1=write, 0=read |
| phy_req_addr | output | 8 | PHY register address |
| phy_req_wdata | output | 8 | Write data |
| phy_rsp_valid | input | 1 | Read data valid pulse |
| phy_rsp_data | input | 8 | Read data |
| cfg_done | output | 1 | Sequence finished pulse |
| cfg_error | output | 1 | DLL lock timeout, with cfg_done |

## Verification
Every timing mode is run at least once. Each run is compared write by write against an expected access list, so a wrong mode-bit value, a swapped tap pair or a misplaced trim write each shows up at a specific position. The pad read-modify-write is tried with two different drive types on top of a changing stored value. This separates an OR from an overwrite. The enhanced-strobe flag is combined with both a legacy code and an HS400 code to show that it overrides each.

Repeated and changed frequency codes separate the skip rule from a mode change. An unknown code and a PHY that never locks cover the two paths that end without a full sequence. Throughout, the PHY model deasserts ready in a regular pattern, and a second start is injected in the middle of one run.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 8;

  // PHY register map (addresses decoded by the PHY)
  localparam logic [REG_AW-1:0] A_DLL  = 8'h00;
  localparam logic [REG_AW-1:0] A_PAD  = 8'h01;
  localparam logic [REG_AW-1:0] A_ITAP = 8'h0C;
  localparam logic [REG_AW-1:0] A_OTAP = 8'h0D;
  localparam logic [REG_AW-1:0] A_MODE = 8'h11;
  localparam logic [REG_AW-1:0] A_TRIM = 8'h12;

  localparam logic [REG_DW-1:0] TRIM_VAL   = 8'h08;
  localparam int                LOCK_BIT   = 4;
  localparam logic [4:0]        DLL_ON_LOW = 5'b01000;

  typedef enum logic [2:0] {
    TM_LEGACY = 3'd0,
    TM_HS     = 3'd1,
    TM_HS200  = 3'd2,
    TM_DDR    = 3'd3,
    TM_HS400  = 3'd4
  } timing_e;

  typedef enum logic [1:0] {
    FQ_200   = 2'd0,
    FQ_100   = 2'd1,
    FQ_50    = 2'd2,
    FQ_OTHER = 2'd3
  } freq_e;

  typedef struct packed {
    logic [REG_DW-1:0] mode_val;
    logic [REG_DW-1:0] otap_val;
    logic [REG_DW-1:0] itap_val;
    logic              pad_rmw;
    logic              dll_on;
  } profile_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MODE,
    ST_PAD_RD,
    ST_PAD_WAIT,
    ST_PAD_WR,
    ST_OTAP,
    ST_ITAP,
    ST_TRIM,
    ST_DLL_RST,
    ST_DLL_EN,
    ST_POLL_RD,
    ST_POLL_WAIT,
    ST_DONE
  } seq_state_e;

  function automatic logic [REG_DW-1:0] tap_enc(input logic [3:0] tap);
    return {{(REG_DW-5){1'b0}}, tap, 1'b1};
  endfunction

  function automatic logic [1:0] freq_to_sel(input logic [1:0] fq);
    case (fq)
      FQ_100:  return 2'd2;
      FQ_50:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/phy_mode_profile.sv
module phy_mode_profile
  import phy_cfg_pkg::*;
(
  input  logic [2:0] timing,
  input  logic       enh_strobe,
  output profile_t   prof,
  output logic       known
);

  always_comb begin
    prof  = '0;
    known = 1'b1;
    if (enh_strobe) begin
      prof.mode_val = 8'h01;
      prof.otap_val = tap_enc(4'd1);
      prof.itap_val = tap_enc(4'd0);
      prof.dll_on   = 1'b1;
    end else begin
      case (timing)
        TM_LEGACY: begin
          prof.mode_val = 8'h04;
        end
        TM_HS: begin
          prof.mode_val = 8'h00;
          prof.otap_val = tap_enc(4'd3);
          prof.itap_val = tap_enc(4'd2);
          prof.dll_on   = 1'b1;
        end
        TM_HS200: begin
          prof.mode_val = 8'h00;
          prof.otap_val = tap_enc(4'd2);
          prof.itap_val = 8'h00;
          prof.pad_rmw  = 1'b1;
          prof.dll_on   = 1'b1;
        end
        TM_DDR: begin
          prof.mode_val = 8'h08;
          prof.otap_val = tap_enc(4'd1);
          prof.itap_val = tap_enc(4'd0);
          prof.dll_on   = 1'b1;
        end
        TM_HS400: begin
          prof.mode_val = 8'h02;
          prof.otap_val = tap_enc(4'd1);
          prof.itap_val = tap_enc(4'd10);
          prof.pad_rmw  = 1'b1;
          prof.dll_on   = 1'b1;
        end
        default: known = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/phy_dll_timer.sv
module phy_dll_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear)             cnt_q <= '0;
    else if (run && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIM);

endmodule

// File: rtl/phy_speed_cfg.sv
module phy_speed_cfg
  import phy_cfg_pkg::*;
#(
  parameter int POLL_LIMIT = 10000,
  parameter int DRV_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_start,
  input  logic [1:0]       cfg_freq,
  input  logic [2:0]       cfg_timing,
  input  logic             cfg_enh_strobe,
  input  logic [DRV_W-1:0] cfg_drv_type,
  output logic             phy_req_valid,
  input  logic             phy_req_ready,
  output logic             phy_req_write,
  output logic [7:0]       phy_req_addr,
  output logic [7:0]       phy_req_wdata,
  input  logic             phy_rsp_valid,
  input  logic [7:0]       phy_rsp_data,
  output logic             cfg_done,
  output logic             cfg_error
);

  localparam int PAD_SH = 2;

  seq_state_e        state_q, state_d;
  profile_t          prof_in, prof_q;
  logic              prof_known;
  logic [1:0]        fsel_q;
  logic [DRV_W-1:0]  drv_q;
  logic [REG_DW-1:0] pad_q;
  logic [1:0]        last_freq_q;
  logic              last_vld_q;
  logic              err_q, err_d;
  logic              xfer, tmr_clear, tmr_run, tmr_exp;
  logic              same_freq;

  phy_mode_profile u_prof (
    .timing     (cfg_timing),
    .enh_strobe (cfg_enh_strobe),
    .prof       (prof_in),
    .known      (prof_known)
  );

  phy_dll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  assign xfer      = phy_req_valid && phy_req_ready;
  assign same_freq = last_vld_q && (last_freq_q == cfg_freq);
  assign tmr_clear = (state_q == ST_DLL_EN) && xfer;
  assign tmr_run   = (state_q == ST_POLL_RD) || (state_q == ST_POLL_WAIT);

  // Request decode from sequencer state
  always_comb begin
    phy_req_valid = 1'b1;
    phy_req_write = 1'b1;
    phy_req_addr  = '0;
    phy_req_wdata = '0;
    case (state_q)
      ST_MODE: begin
        phy_req_addr  = A_MODE;
        phy_req_wdata = prof_q.mode_val;
      end
      ST_PAD_RD: begin
        phy_req_write = 1'b0;
        phy_req_addr  = A_PAD;
      end
      ST_PAD_WR: begin
        phy_req_addr  = A_PAD;
        phy_req_wdata = pad_q | (REG_DW'(drv_q) << PAD_SH);
      end
      ST_OTAP: begin
        phy_req_addr  = A_OTAP;
        phy_req_wdata = prof_q.otap_val;
      end
      ST_ITAP: begin
        phy_req_addr  = A_ITAP;
        phy_req_wdata = prof_q.itap_val;
      end
      ST_TRIM: begin
        phy_req_addr  = A_TRIM;
        phy_req_wdata = TRIM_VAL;
      end
      ST_DLL_RST: begin
        phy_req_addr  = A_DLL;
        phy_req_wdata = '0;
      end
      ST_DLL_EN: begin
        phy_req_addr  = A_DLL;
        phy_req_wdata = {1'b0, fsel_q, DLL_ON_LOW};
      end
      ST_POLL_RD: begin
        phy_req_write = 1'b0;
        phy_req_addr  = A_DLL;
      end
      default: begin
        phy_req_valid = 1'b0;
        phy_req_write = 1'b0;
      end
    endcase
  end

  // Next-state sequencing
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (cfg_start) begin
          err_d = 1'b0;
          if (same_freq || !prof_known) state_d = ST_DONE;
          else                          state_d = ST_MODE;
        end
      end
      ST_MODE:     if (xfer) state_d = prof_q.pad_rmw ? ST_PAD_RD : ST_OTAP;
      ST_PAD_RD:   if (xfer) state_d = ST_PAD_WAIT;
      ST_PAD_WAIT: if (phy_rsp_valid) state_d = ST_PAD_WR;
      ST_PAD_WR:   if (xfer) state_d = ST_OTAP;
      ST_OTAP:     if (xfer) state_d = ST_ITAP;
      ST_ITAP:     if (xfer) state_d = prof_q.dll_on ? ST_TRIM : ST_DLL_RST;
      ST_TRIM:     if (xfer) state_d = ST_DLL_RST;
      ST_DLL_RST:  if (xfer) state_d = prof_q.dll_on ? ST_DLL_EN : ST_DONE;
      ST_DLL_EN:   if (xfer) state_d = ST_POLL_RD;
      ST_POLL_RD:  if (xfer) state_d = ST_POLL_WAIT;
      ST_POLL_WAIT: begin
        if (phy_rsp_valid) begin
          if (phy_rsp_data[LOCK_BIT]) begin
            state_d = ST_DONE;
          end else if (tmr_exp) begin
            state_d = ST_DONE;
            err_d   = 1'b1;
          end else begin
            state_d = ST_POLL_RD;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      err_q       <= 1'b0;
      prof_q      <= '0;
      fsel_q      <= '0;
      drv_q       <= '0;
      pad_q       <= '0;
      last_freq_q <= '0;
      last_vld_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (state_q == ST_IDLE && cfg_start) begin
        prof_q      <= prof_in;
        fsel_q      <= freq_to_sel(cfg_freq);
        drv_q       <= cfg_drv_type;
        last_freq_q <= cfg_freq;
        last_vld_q  <= 1'b1;
      end
      if (state_q == ST_PAD_WAIT && phy_rsp_valid) pad_q <= phy_rsp_data;
    end
  end

  assign cfg_done  = (state_q == ST_DONE);
  assign cfg_error = (state_q == ST_DONE) && err_q;

endmodule

// File: rtl/phy_speed_cfg_chk.sv
module phy_speed_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_req_valid,
  input logic       phy_req_ready,
  input logic       phy_req_write,
  input logic [7:0] phy_req_addr,
  input logic [7:0] phy_req_wdata,
  input logic       cfg_done,
  input logic       cfg_error
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req_valid && !phy_req_ready) |=>
      (phy_req_valid && $stable(phy_req_addr) && $stable(phy_req_write) && $stable(phy_req_wdata)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !phy_req_valid);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> cfg_done);

  // R2
  tap_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req_valid && phy_req_write && phy_req_addr == 8'h0D && phy_req_wdata != 8'h00)
      |-> phy_req_wdata[0]);

  // R5
  dll_enable_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req_valid && phy_req_write && phy_req_addr == 8'h00 && phy_req_wdata != 8'h00)
      |-> (phy_req_wdata[4:0] == 5'h08 && !phy_req_wdata[7]));

  // R4
  trim_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req_valid && phy_req_write && phy_req_addr == 8'h12) |-> (phy_req_wdata == 8'h08));

endmodule

bind phy_speed_cfg phy_speed_cfg_chk u_chk (.*);

// File: tb/phy_speed_cfg_tb.sv
module phy_speed_cfg_tb;
  import phy_cfg_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_start = 1'b0;
  logic [1:0] cfg_freq = '0;
  logic [2:0] cfg_timing = '0;
  logic       cfg_enh_strobe = 1'b0;
  logic [1:0] cfg_drv_type = '0;
  logic       phy_req_valid, phy_req_write;
  logic       phy_req_ready = 1'b1;
  logic [7:0] phy_req_addr, phy_req_wdata;
  logic       phy_rsp_valid = 1'b0;
  logic [7:0] phy_rsp_data = '0;
  logic       cfg_done, cfg_error;

  always #5 clk = ~clk;

  phy_speed_cfg #(.POLL_LIMIT(64), .DRV_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_freq(cfg_freq),
    .cfg_timing(cfg_timing), .cfg_enh_strobe(cfg_enh_strobe), .cfg_drv_type(cfg_drv_type),
    .phy_req_valid(phy_req_valid), .phy_req_ready(phy_req_ready), .phy_req_write(phy_req_write),
    .phy_req_addr(phy_req_addr), .phy_req_wdata(phy_req_wdata), .phy_rsp_valid(phy_rsp_valid),
    .phy_rsp_data(phy_rsp_data), .cfg_done(cfg_done), .cfg_error(cfg_error)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  mregs [0:63];
  int   poll_cnt = 0;
  int   lock_after = 2;
  bit   never_lock = 0;
  int   reads_dll = 0;
  int   done_seen = 0;
  bit   exp_err = 0;
  string cur_tag = "";
  int   rdy_cnt = 0;
  bit   rsp_pend = 0;
  logic [7:0] rsp_val = '0;
  int   cyc = 0;
  bit   last_vld = 0;
  logic [1:0] last_fq = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // PHY model + monitor (scoreboard consumer)
  always @(negedge clk) begin
    if (rst_n) begin
      rdy_cnt++;
      phy_req_ready = (rdy_cnt % 4) != 2;
      phy_rsp_valid = rsp_pend;
      phy_rsp_data  = rsp_val;
      rsp_pend      = 0;
      if (phy_req_valid && phy_req_ready) begin
        if (phy_req_write) begin
          mregs[phy_req_addr[5:0]] = phy_req_wdata;
          if (phy_req_addr == 8'h00) poll_cnt = 0;
          if (exp_q.size() == 0) begin
            check(0, cur_tag, "unexpected write", {phy_req_addr, phy_req_wdata}, 0);
          end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check({phy_req_addr, phy_req_wdata} == e, cur_tag, "write addr/data",
                  {phy_req_addr, phy_req_wdata}, e);
          end
        end else begin
          if (phy_req_addr == 8'h00) begin
            rsp_val = mregs[0] & 8'hEF;
            if (!never_lock && poll_cnt >= lock_after) rsp_val[4] = 1'b1;
            poll_cnt++;
            reads_dll++;
          end else begin
            rsp_val = mregs[phy_req_addr[5:0]];
          end
          rsp_pend = 1;
        end
      end
      if (cfg_done) begin
        done_seen++;
        check(exp_q.size() == 0, cur_tag, "writes left at done", exp_q.size(), 0);
        check(cfg_error == exp_err, cur_tag, "error flag", cfg_error, exp_err);
      end
    end
  end

  // Driver: builds expected write list, starts the block, waits for done
  task automatic run_cfg(input logic [2:0] tm, input logic [1:0] fq, input bit enh,
                         input logic [1:0] drv, input bit want_err, input bit poke,
                         input string tag);
    logic [7:0] mv, ov, iv;
    bit pad, dll, known, skip;
    logic [1:0] fs;
    int d0, guard;
    cur_tag = tag;
    skip = last_vld && (last_fq == fq);
    last_vld = 1; last_fq = fq;
    known = 1; pad = 0; dll = 1; mv = 0; ov = 0; iv = 0;
    if (enh) begin mv = 8'h01; ov = 8'h03; iv = 8'h01; end
    else case (tm)
      3'd0: begin mv = 8'h04; dll = 0; end
      3'd1: begin mv = 8'h00; ov = 8'h07; iv = 8'h05; end
      3'd2: begin mv = 8'h00; ov = 8'h05; iv = 8'h00; pad = 1; end
      3'd3: begin mv = 8'h08; ov = 8'h03; iv = 8'h01; end
      3'd4: begin mv = 8'h02; ov = 8'h03; iv = 8'h15; pad = 1; end
      default: known = 0;
    endcase
    fs = (fq == 2'd1) ? 2'd2 : (fq == 2'd2) ? 2'd1 : 2'd0;
    exp_q.delete();
    if (!skip && known) begin
      exp_q.push_back({8'h11, mv});
      if (pad) exp_q.push_back({8'h01, mregs[1] | {4'b0, drv, 2'b0}});
      exp_q.push_back({8'h0D, ov});
      exp_q.push_back({8'h0C, iv});
      if (dll) exp_q.push_back({8'h12, 8'h08});
      exp_q.push_back({8'h00, 8'h00});
      if (dll) exp_q.push_back({8'h00, {1'b0, fs, 5'b01000}});
    end
    exp_err = want_err;
    reads_dll = 0;
    d0 = done_seen;
    @(negedge clk);
    cfg_timing = tm; cfg_freq = fq; cfg_enh_strobe = enh; cfg_drv_type = drv;
    cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      cfg_timing = 3'd1; cfg_freq = fq + 2'd1; cfg_enh_strobe = 0;
      cfg_start = 1;   // R10: ignored while busy
      @(negedge clk);
      cfg_start = 0;
    end
    guard = 0;
    while (done_seen == d0 && guard < 5000) begin @(negedge clk); guard++; end
    check(done_seen == d0 + 1, tag, "done pulses", done_seen - d0, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (phy_req_valid || cfg_done) begin
        check(0, tag, "R10 activity after done", {phy_req_valid, cfg_done}, 0);
        break;
      end
    end
    check(done_seen == d0 + 1, tag, "R10 single done", done_seen - d0, 1);
    if (!skip && known && dll && !want_err)
      check(reads_dll == lock_after + 1, tag, "R5 lock poll reads", reads_dll, lock_after + 1);
    if (want_err)
      check(reads_dll > 1, tag, "R6 polls before timeout", reads_dll, 2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mregs[i] = 8'h00;
    mregs[1] = 8'h41;
    repeat (3) @(negedge clk);
    check(!cfg_done && !cfg_error && !phy_req_valid, "R12", "reset outputs",
          {cfg_done, cfg_error, phy_req_valid}, 0);
    rst_n = 1;
    run_cfg(3'd0, FQ_200, 0, 2'd0, 0, 0, "R1 R2 legacy");
    run_cfg(3'd1, FQ_100, 0, 2'd0, 0, 0, "R1 R2 R4 R5 high-speed");
    run_cfg(3'd3, FQ_100, 0, 2'd0, 0, 0, "R7 same freq skip");
    run_cfg(3'd2, FQ_50,  0, 2'd2, 0, 0, "R3 HS200 pad");
    lock_after = 5;
    run_cfg(3'd4, FQ_200, 0, 2'd3, 0, 1, "R3 R10 R11 HS400 busy start");
    lock_after = 0;
    run_cfg(3'd0, FQ_100, 1, 2'd0, 0, 0, "R8 enh over legacy");
    run_cfg(3'd3, FQ_OTHER, 0, 2'd0, 0, 0, "R5 DDR other freq");
    run_cfg(3'd6, FQ_200, 0, 2'd0, 0, 0, "R9 unknown mode");
    never_lock = 1;
    run_cfg(3'd1, FQ_50, 0, 2'd0, 1, 0, "R6 lock timeout");
    never_lock = 0;
    lock_after = 1;
    run_cfg(3'd4, FQ_100, 1, 2'd3, 0, 0, "R8 enh over HS400");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule